// File: doc/BRIEF.md
# Postfix Expression Evaluator

This block evaluates integer arithmetic expressions written in postfix (reverse Polish) order. A producer sends one token at a time over a valid/ready handshake. A token is an operand value, an operator, or an end marker. Operand values go onto an internal register stack. An operator takes the two newest entries, combines them, and puts the single result back in their place. The end marker returns the single remaining entry as the result and clears the stack, ready for the next expression.

The stack holds 64 words of 16-bit two's complement data, and all arithmetic wraps modulo 2^16. Full and empty flags are visible at the ports. Three kinds of fault are each reported as a one-cycle pulse: a push into a full stack, an operator that finds fewer than two entries, and an end marker that does not find exactly one entry. Each accepted operator takes two cycles, and the block holds ready low for the second of them.

Top module: `rpn_eval`

## Requirements
- R1: `tok_ready_o` is high whenever no operator is executing, and a token is accepted on a rising clock edge where `tok_valid_i` and `tok_ready_o` are both high. After an operator is accepted with at least two entries present, `tok_ready_o` is low for exactly the next cycle and then high again.
- R2: `tok_kind_i` is encoded as 0 = operand (value on `tok_data_i`), 1 = operator (code on `tok_op_i`), 2 = end of expression, 3 = no-op. An accepted no-op token changes neither the stack nor any output.
- R3: An accepted operand is pushed when fewer than 64 entries are present. An operand accepted while the stack is full is discarded, the stack is left unchanged, and `ovf_o` is high for exactly the cycle after acceptance.
- R4: An operator takes the entry below the top as its left operand and the top entry as its right operand. Codes are 0 = add, 1 = subtract (left minus right), 2 = multiply (low 16 bits of the product), 3 = constant zero. The two entries are replaced by the wrapped 16-bit result, which is in place one cycle after acceptance.
- R5: An operator accepted with fewer than two entries present leaves the stack unchanged, does not drop `tok_ready_o`, and drives `udf_o` high for exactly the cycle after acceptance.
- R6: In the cycle after an end token is accepted, `res_valid_o` is high for one cycle. If exactly one entry was present, `res_err_o` is 0 and `res_data_o` carries that entry. Otherwise `res_err_o` is 1 and `res_data_o` is 0. In every case the stack is empty from that cycle on.
- R7: `empty_o` is high exactly when no entries are present, and `full_o` is high exactly when 64 entries are present.
- R8: After reset the stack is empty, `tok_ready_o` is high, and `res_valid_o`, `res_err_o`, `ovf_o` and `udf_o` are low.
- R9: The token sequence 3 4 mul 5 6 mul add end produces a valid, error-free result of 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | A token is presented |
| tok_ready_o | output | 1 | The block can accept a token |
| tok_kind_i | input | 2 | Token kind: 0 operand, 1 operator, 2 end, 3 no-op |
| tok_op_i | input | 2 | Operator code: 0 add, 1 sub, 2 mul, 3 zero |
| tok_data_i | input | 16 | Operand value |
| res_valid_o | output | 1 | One-cycle pulse when an expression finishes |
| res_err_o | output | 1 | The finished expression was malformed |
| res_data_o | output | 16 | Result value, 0 on error |
| ovf_o | output | 1 | Pulse: a push was dropped because the stack was full |
| udf_o | output | 1 | Pulse: an operator found fewer than two entries |
| empty_o | output | 1 | The stack holds no entries |
| full_o | output | 1 | The stack holds 64 entries |

## Verification
A wrong stack pointer shows first in the flags. `empty_o` or `full_o` diverges from the reference in the cycle after the faulty push or fold. If the pointer error does not reach the flags, it shows at the next end token as a wrong `res_err_o`. A swapped operand order or a wrong operator shows up only at the result, so every operator is driven with asymmetric values, including a subtraction with a negative result and a product that wraps. The reference model is compared with the ports on every cycle, so a ready held low too long, or an error pulse that is missing or stretched, is caught within one cycle.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  typedef enum logic [1:0] {TK_NUM = 2'd0, TK_OP = 2'd1, TK_END = 2'd2, TK_NOP = 2'd3} tok_kind_e;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_ZERO = 2'd3} op_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_EXEC = 1'b1} ctrl_st_e;
endpackage

// File: rtl/rpn_alu.sv
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  op_e           op_i,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      OP_MUL:  res_o = lhs_i * rhs_i;  // low DW bits only
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rpn_stack.sv
// DEPTH must be a power of two: sp_q wraps to 0 on the last push and full_q tells full from empty.
module rpn_stack #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          fold_i,
  input  logic [DW-1:0] fold_data_i,
  input  logic          clr_i,
  output logic [DW-1:0] top_o,
  output logic [DW-1:0] below_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          one_o,
  output logic          two_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [PW-1:0] sp_q;
  logic          full_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] top_idx, below_idx;

  assign top_idx   = sp_q - PW'(1);
  assign below_idx = sp_q - PW'(2);
  assign top_o     = mem_q[top_idx];
  assign below_o   = mem_q[below_idx];
  assign full_o    = full_q;
  assign empty_o   = (sp_q == '0) && !full_q;
  assign one_o     = (sp_q == PW'(1)) && !full_q;
  assign two_o     = full_q || (sp_q >= PW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      sp_q   <= '0;
      full_q <= 1'b0;
    end else if (push_i) begin
      sp_q   <= sp_q + PW'(1);
      full_q <= (sp_q == PW'(DEPTH - 1));
    end else if (fold_i) begin
      sp_q   <= sp_q - PW'(1);
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i)      mem_q[sp_q]      <= push_data_i;
    else if (fold_i) mem_q[below_idx] <= fold_data_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_q);
  assert_fold_needs_two_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_i |-> two_o);
  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
  assert_one_command_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_i, fold_i, clr_i}));
endmodule

// File: rtl/rpn_ctrl.sv
module rpn_ctrl
  import rpn_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_valid_i,
  output logic          tok_ready_o,
  input  tok_kind_e     kind_i,
  input  op_e           op_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] top_i,
  input  logic [DW-1:0] below_i,
  input  logic          empty_i,
  input  logic          full_i,
  input  logic          one_i,
  input  logic          two_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          fold_o,
  output logic          clr_o,
  output op_e           alu_op_o,
  output logic [DW-1:0] lhs_o,
  output logic [DW-1:0] rhs_o,
  output logic          res_valid_o,
  output logic          res_err_o,
  output logic [DW-1:0] res_data_o,
  output logic          ovf_o,
  output logic          udf_o
);
  ctrl_st_e st_q;
  logic     acc;

  assign tok_ready_o = (st_q == ST_IDLE);
  assign acc         = tok_valid_i && tok_ready_o;
  assign push_o      = acc && (kind_i == TK_NUM) && !full_i;
  assign push_data_o = data_i;
  assign fold_o      = (st_q == ST_EXEC);
  assign clr_o       = acc && (kind_i == TK_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      alu_op_o    <= OP_ADD;
      lhs_o       <= '0;
      rhs_o       <= '0;
      res_valid_o <= 1'b0;
      res_err_o   <= 1'b0;
      res_data_o  <= '0;
      ovf_o       <= 1'b0;
      udf_o       <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      res_err_o   <= 1'b0;
      ovf_o       <= 1'b0;
      udf_o       <= 1'b0;
      if (st_q == ST_EXEC) begin
        st_q <= ST_IDLE;
      end else if (acc) begin
        unique case (kind_i)
          TK_NUM: if (full_i) ovf_o <= 1'b1;
          TK_OP: begin
            if (two_i) begin
              lhs_o    <= below_i;
              rhs_o    <= top_i;
              alu_op_o <= op_i;
              st_q     <= ST_EXEC;
            end else begin
              udf_o <= 1'b1;
            end
          end
          TK_END: begin
            res_valid_o <= 1'b1;
            res_err_o   <= !one_i;
            res_data_o  <= one_i ? top_i : '0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_busy_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_ready_o |=> tok_ready_o);
  assert_overflow_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == TK_NUM && full_i) |=> (ovf_o && full_i));
  assert_underflow_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == TK_OP && !two_i) |=> (udf_o && tok_ready_o && $stable(empty_i)));
  assert_end_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == TK_END) |=> (empty_i && res_valid_o));
endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
  import rpn_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_valid_i,
  output logic          tok_ready_o,
  input  logic [1:0]    tok_kind_i,
  input  logic [1:0]    tok_op_i,
  input  logic [DW-1:0] tok_data_i,
  output logic          res_valid_o,
  output logic          res_err_o,
  output logic [DW-1:0] res_data_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          empty_o,
  output logic          full_o
);
  logic          push, fold, clr, one, two;
  logic [DW-1:0] push_data, top, below, lhs, rhs, alu_res;
  op_e           alu_op;

  rpn_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .push_data_i(push_data),
    .fold_i(fold), .fold_data_i(alu_res), .clr_i(clr),
    .top_o(top), .below_o(below),
    .empty_o(empty_o), .full_o(full_o), .one_o(one), .two_o(two)
  );

  rpn_ctrl #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tok_valid_i(tok_valid_i), .tok_ready_o(tok_ready_o),
    .kind_i(tok_kind_e'(tok_kind_i)), .op_i(op_e'(tok_op_i)), .data_i(tok_data_i),
    .top_i(top), .below_i(below),
    .empty_i(empty_o), .full_i(full_o), .one_i(one), .two_i(two),
    .push_o(push), .push_data_o(push_data), .fold_o(fold), .clr_o(clr),
    .alu_op_o(alu_op), .lhs_o(lhs), .rhs_o(rhs),
    .res_valid_o(res_valid_o), .res_err_o(res_err_o), .res_data_o(res_data_o),
    .ovf_o(ovf_o), .udf_o(udf_o)
  );

  rpn_alu #(.DW(DW)) u_alu (
    .op_i(alu_op), .lhs_i(lhs), .rhs_i(rhs), .res_o(alu_res)
  );

  assert_result_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_err_o) |-> (res_data_o == '0));
endmodule

// File: tb/tb_rpn_eval.sv
`timescale 1ns/1ps
module tb_rpn_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_kind = 2'd0;
  logic [1:0]  tok_op = 2'd0;
  logic [15:0] tok_data = '0;
  logic        tok_ready, res_valid, res_err, ovf, udf, empty, full;
  logic [15:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #10 clk = ~clk;

  rpn_eval dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
    .tok_kind_i(tok_kind), .tok_op_i(tok_op), .tok_data_i(tok_data),
    .res_valid_o(res_valid), .res_err_o(res_err), .res_data_o(res_data),
    .ovf_o(ovf), .udf_o(udf), .empty_o(empty), .full_o(full)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] q[$];
  bit          m_busy = 1'b0;
  logic [1:0]  m_op = 2'd0;
  bit          e_ovf = 1'b0, e_udf = 1'b0, e_rv = 1'b0, e_err = 1'b0;
  logic [15:0] e_res = '0;

  function automatic logic [15:0] calc(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    int r;
    case (op)
      2'd0: r = int'(a) + int'(b);
      2'd1: r = int'(a) - int'(b);
      2'd2: r = int'(a) * int'(b);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 1'b0;
      e_ovf = 0; e_udf = 0; e_rv = 0; e_err = 0;
    end else begin
      e_ovf = 0; e_udf = 0; e_rv = 0; e_err = 0;
      if (m_busy) begin
        logic [15:0] b, a;
        b = q.pop_back();
        a = q.pop_back();
        q.push_back(calc(m_op, a, b));
        m_busy = 1'b0;
      end else if (tok_valid) begin
        case (tok_kind)
          2'd0: if (q.size() == 64) e_ovf = 1; else q.push_back(tok_data);
          2'd1: if (q.size() < 2) e_udf = 1; else begin m_busy = 1'b1; m_op = tok_op; end
          2'd2: begin
            e_rv  = 1;
            e_err = (q.size() != 1);
            e_res = (q.size() == 1) ? q[0] : 16'd0;
            q.delete();
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      check("R1 ready", int'(tok_ready), int'(!m_busy));
      check("R7 empty", int'(empty), int'(q.size() == 0));
      check("R7 full", int'(full), int'(q.size() == 64));
      check("R3 ovf", int'(ovf), int'(e_ovf));
      check("R5 udf", int'(udf), int'(e_udf));
      check("R6 res_valid", int'(res_valid), int'(e_rv));
      if (e_rv) begin
        check("R6 res_err", int'(res_err), int'(e_err));
        check("R4 R6 res_data", int'(res_data), int'(e_res));
      end
    end
  end

  // holds the token until the edge that accepts it; returns at the following negedge
  task automatic send(input logic [1:0] k, input logic [1:0] o, input logic [15:0] d);
    bit r;
    tok_valid = 1'b1; tok_kind = k; tok_op = o; tok_data = d;
    forever begin
      r = tok_ready;
      @(negedge clk);
      if (r) break;
    end
  endtask

  task automatic num(input int v);  send(2'd0, 2'd0, v[15:0]); endtask
  task automatic opr(input int c);  send(2'd1, c[1:0], 16'd0); endtask
  task automatic fin();             send(2'd2, 2'd0, 16'd0);   endtask
  task automatic idle(input int n);
    tok_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 ready", int'(tok_ready), 1);
    check("R8 empty", int'(empty), 1);
    check("R8 full", int'(full), 0);
    check("R8 pulses", int'({res_valid, res_err, ovf, udf}), 0);
    rst_n = 1'b1;
    live  = 1'b1;
    @(negedge clk);

    // R9 worked example
    num(3); num(4); opr(2); num(5); num(6); opr(2); opr(0); fin();
    check("R9 result", int'(res_data), 42);
    check("R9 valid", int'(res_valid && !res_err), 1);
    idle(2);

    // R4 operand order and wrap
    num(10); num(3); opr(1); fin();
    check("R4 sub order", int'(res_data), 7);
    num(3); num(10); opr(1); fin();
    check("R4 sub negative", int'(res_data), 16'hFFF9);
    num(300); num(300); opr(2); fin();
    check("R4 mul wrap", int'(res_data), 24464);
    num(16'hFFFF); num(2); opr(0); fin();
    check("R4 add wrap", int'(res_data), 1);
    num(77); num(5); opr(3); fin();
    check("R4 zero op", int'(res_data), 0);

    // R1 busy cycle: ready low exactly one cycle after an operator
    num(8); num(9);
    tok_valid = 1'b1; tok_kind = 2'd1; tok_op = 2'd0;
    @(negedge clk);
    check("R1 busy low", int'(tok_ready), 0);
    tok_valid = 1'b0;
    @(negedge clk);
    check("R1 ready back", int'(tok_ready), 1);
    fin();
    check("R1 sum", int'(res_data), 17);

    // R5 underflow on empty and on one entry
    opr(0);
    check("R5 udf empty", int'(udf), 1);
    num(4); opr(1);
    check("R5 udf one", int'(udf), 1);
    check("R5 no busy", int'(tok_ready), 1);
    fin();
    check("R5 stack intact", int'(res_data), 4);

    // R2 no-op token has no effect
    num(55); send(2'd3, 2'd2, 16'd1234); send(2'd3, 2'd0, 16'd9);
    check("R2 still one", int'(empty), 0);
    fin();
    check("R2 untouched", int'(res_data), 55);

    // R6 malformed: zero and two entries
    fin();
    check("R6 err empty", int'(res_err), 1);
    num(1); num(2); fin();
    check("R6 err two", int'(res_err), 1);
    check("R6 data zero", int'(res_data), 0);
    idle(1);
    check("R6 cleared", int'(empty), 1);

    // R3 and R7: fill, overflow, drain
    for (int i = 1; i <= 64; i++) num(i);
    check("R7 full", int'(full), 1);
    num(999);
    check("R3 ovf", int'(ovf), 1);
    for (int i = 0; i < 63; i++) opr(0);
    idle(1);
    check("R7 not full", int'(full), 0);
    fin();
    check("R3 dropped push", int'(res_data), 2080);
    idle(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule